// File: doc/BRIEF.md
# Built-In Input Test Pattern Source

This block sits at the head of a receive filter chain, between the converter input pins and the internal sample bus. In normal operation it passes each converter word and its enable through one register stage. When a test source is selected, the converter is disconnected and the bus instead carries either a fixed most-negative sample or words from an internal pseudo-random generator. Known stimulus can then be pushed through the filters without touching the board.

A separate option imitates a two-input converter that interleaves its channels in time. The bus enable then alternates every clock, as if a channel-select line from such a converter were driving it. The filtered output comes back into a multiple-input signature register. This register folds every valid output word into a 16-bit signature, which test software compares against a precomputed value.

Top module: `tpat_src`

## Requirements
- R1: While `rst_n` is low, `bus_data` is 0, `bus_en` is 0 and `misr_sig` is 0. Reset also loads the pseudo-random state with the seed 0x0001.
- R2: When `cfg_src[1]` is 0 (codes 2'b00 and 2'b01), `bus_data` and `bus_en` equal the `adc_data` and `adc_en` values present one clock earlier.
- R3: When `cfg_src` is 2'b10, `bus_data` is 0x2000 one clock later, which is the most negative 14-bit two's complement value. `adc_data` has no effect on the bus in this mode.
- R4: When `cfg_src` is 2'b11, `bus_data` one clock later equals the low 14 bits of a 15-bit LFSR state. The state then advances to `{s[13:0], s[14]^s[13]}`, so the sequence repeats every 32767 words and the 32768th word equals the first.
- R5: The LFSR state holds whenever `cfg_src` is not 2'b11. A later return to 2'b11 resumes the sequence where it stopped.
- R6: With `cfg_src[1]` at 1 and `cfg_tdm` at 0, `bus_en` is 1 every clock. With `cfg_src[1]` at 1 and `cfg_tdm` at 1, `bus_en` alternates every clock, and the first registered value after entering this mode is 1. With `cfg_src[1]` at 0, `cfg_tdm` has no effect.
- R7: On a clock where `sig_valid` is 1 and `misr_clr` is 0, the signature becomes `{s[14:0],1'b0} ^ (s[15] ? 16'h1021 : 0) ^ sig_data`.
- R8: On a clock where `sig_valid` and `misr_clr` are both 0, the signature holds its value.
- R9: `misr_clr` set to 1 makes the signature 0 on the next clock, even when `sig_valid` is 1 on the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_src | input | 2 | Bus source: 00/01 converter, 10 most-negative constant, 11 pseudo-random |
| cfg_tdm | input | 1 | Alternate the bus enable as a two-input interleaved converter would |
| adc_data | input | 14 | Converter sample, two's complement |
| adc_en | input | 1 | Converter sample enable |
| bus_data | output | 14 | Sample delivered to the filter chain |
| bus_en | output | 1 | Enable delivered to the filter chain |
| sig_data | input | 16 | Filter output word to compress |
| sig_valid | input | 1 | `sig_data` is valid on this clock |
| misr_clr | input | 1 | Clear the signature |
| misr_sig | output | 16 | Current signature |

## Verification
Two situations are hard to reach from the ports. The first is the wrap of the pseudo-random sequence. The bench reaches it by running the generator for more than a full period of 32767 words, comparing every word with its own arithmetic model, and checking that word 32768 equals the seed. The second is a pause in the sequence. The bench leaves PRBS mode part-way through, switches to converter data for a while, and then re-enters PRBS mode. The words that follow must continue the sequence without a skip, which shows that the held state never leaked onto the bus. The converter path is swept over all 16384 input codes, and the signature register is exercised with a clear that collides with a valid word.

// File: rtl/tpat_pkg.sv
package tpat_pkg;

   typedef enum logic [1:0] {
      SRC_LIVE   = 2'b00,
      SRC_LIVE_B = 2'b01,
      SRC_NFS    = 2'b10,
      SRC_PRBS   = 2'b11
   } src_mode_e;

   // Feedback tap mask for a maximal-length Fibonacci LFSR of the given width.
   // Bit k of the mask set means state bit k feeds the XOR.
   // Unsupported widths return 0.
   function automatic logic [31:0] prbs_taps(input int w);
      logic [31:0] m;
      m = '0;
      case (w)
         7:  begin m[6]  = 1'b1; m[5]  = 1'b1; end
         9:  begin m[8]  = 1'b1; m[4]  = 1'b1; end
         15: begin m[14] = 1'b1; m[13] = 1'b1; end
         17: begin m[16] = 1'b1; m[13] = 1'b1; end
         23: begin m[22] = 1'b1; m[17] = 1'b1; end
         31: begin m[30] = 1'b1; m[27] = 1'b1; end
         default: m = '0;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/tpat_prbs.sv
module tpat_prbs #(
   parameter int          W     = 15,
   parameter int          OUT_W = 14,
   parameter logic [31:0] SEED  = 32'h1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [OUT_W-1:0] word
);
   localparam logic [31:0]  TAPS_ALL = tpat_pkg::prbs_taps(W);
   localparam logic [W-1:0] TAP_MASK = TAPS_ALL[W-1:0];
   localparam logic [W-1:0] SEED_W   = SEED[W-1:0];

   generate
      if (W < 2 || W > 32) begin : g_bad_width
         $error("tpat_prbs: W must lie in 2..32");
      end
      if (TAP_MASK == '0) begin : g_bad_taps
         $error("tpat_prbs: no tap set for this width");
      end
      if (SEED_W == '0) begin : g_bad_seed
         $error("tpat_prbs: seed must be nonzero");
      end
      if (OUT_W > W) begin : g_bad_out
         $error("tpat_prbs: OUT_W exceeds W");
      end
   endgenerate

   logic [W-1:0] state;
   logic         fb;

   assign fb   = ^(state & TAP_MASK);
   assign word = state[OUT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   state <= SEED_W;
      else if (adv) state <= {state[W-2:0], fb};
   end

   // R4: a maximal-length register never falls into the all-zero lock-up state
   p_prbs_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0);

   // R5: the state is frozen while the generator is not selected
   p_prbs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(state));

endmodule

// File: rtl/tpat_srcsel.sv
module tpat_srcsel #(
   parameter int DATA_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic              tdm_emul,
   input  logic [DATA_W-1:0] adc_data,
   input  logic              adc_en,
   input  logic [DATA_W-1:0] prbs_word,
   output logic              prbs_adv,
   output logic [DATA_W-1:0] bus_data,
   output logic              bus_en
);
   import tpat_pkg::*;

   localparam logic [DATA_W-1:0] NEG_FS = {1'b1, {(DATA_W-1){1'b0}}};

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("tpat_srcsel: DATA_W must be at least 2");
      end
   endgenerate

   logic              test_sel;
   logic              tdm_act;
   logic              phase;
   logic [DATA_W-1:0] nxt_data;
   logic              nxt_en;

   assign test_sel = mode[1];
   assign tdm_act  = test_sel & tdm_emul;
   assign prbs_adv = (mode == SRC_PRBS);

   always_comb begin
      case (mode)
         SRC_NFS:  nxt_data = NEG_FS;
         SRC_PRBS: nxt_data = prbs_word;
         default:  nxt_data = adc_data;
      endcase
      if (!test_sel)     nxt_en = adc_en;
      else if (tdm_emul) nxt_en = ~phase;
      else               nxt_en = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= 1'b0;
         bus_data <= '0;
         bus_en   <= 1'b0;
      end else begin
         phase    <= tdm_act ? ~phase : 1'b0;
         bus_data <= nxt_data;
         bus_en   <= nxt_en;
      end
   end

   // R2: converter path delivers its sample and enable one clock later
   p_live_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !test_sel |=> (bus_data == $past(adc_data)) && (bus_en == $past(adc_en)));

   // R3: constant source produces the most negative code
   p_neg_fs_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SRC_NFS) |=> (bus_data == NEG_FS));

   // R6: interleave emulation alternates the enable on consecutive clocks
   p_tdm_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tdm_act && $past(tdm_act)) |=> (bus_en != $past(bus_en)));

   // R6: test source without emulation keeps the enable high
   p_test_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (test_sel && !tdm_emul) |=> bus_en);

endmodule

// File: rtl/tpat_misr.sv
module tpat_misr #(
   parameter int             W    = 16,
   parameter logic [W-1:0]   POLY = 16'h1021
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         valid,
   input  logic [W-1:0] din,
   output logic [W-1:0] sig
);
   generate
      if (W < 2) begin : g_bad_w
         $error("tpat_misr: W must be at least 2");
      end
      if (POLY[0] == 1'b0) begin : g_bad_poly
         $error("tpat_misr: polynomial needs its constant term");
      end
   endgenerate

   logic [W-1:0] shifted;

   assign shifted = {sig[W-2:0], 1'b0} ^ (sig[W-1] ? POLY : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sig <= '0;
      else if (clr)   sig <= '0;
      else if (valid) sig <= shifted ^ din;
   end

   // R9: a clear wins over a valid word on the same clock
   p_misr_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (sig == '0));

   // R8: no valid word, no clear: signature holds
   p_misr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !valid) |=> $stable(sig));

endmodule

// File: rtl/tpat_src.sv
module tpat_src #(
   parameter int          DATA_W    = 14,
   parameter int          PRBS_W    = 15,
   parameter logic [31:0] PRBS_SEED = 32'h1,
   parameter int          MISR_W    = 16,
   parameter logic [MISR_W-1:0] MISR_POLY = 16'h1021
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_src,
   input  logic              cfg_tdm,
   input  logic [DATA_W-1:0] adc_data,
   input  logic              adc_en,
   output logic [DATA_W-1:0] bus_data,
   output logic              bus_en,
   input  logic [MISR_W-1:0] sig_data,
   input  logic              sig_valid,
   input  logic              misr_clr,
   output logic [MISR_W-1:0] misr_sig
);
   generate
      if (PRBS_W < DATA_W) begin : g_bad_prbs
         $error("tpat_src: PRBS_W must cover DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0] prbs_word;
   logic              prbs_adv;

   tpat_prbs #(
      .W     (PRBS_W),
      .OUT_W (DATA_W),
      .SEED  (PRBS_SEED)
   ) u_prbs (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (prbs_adv),
      .word  (prbs_word)
   );

   tpat_srcsel #(
      .DATA_W (DATA_W)
   ) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (cfg_src),
      .tdm_emul  (cfg_tdm),
      .adc_data  (adc_data),
      .adc_en    (adc_en),
      .prbs_word (prbs_word),
      .prbs_adv  (prbs_adv),
      .bus_data  (bus_data),
      .bus_en    (bus_en)
   );

   tpat_misr #(
      .W    (MISR_W),
      .POLY (MISR_POLY)
   ) u_misr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (misr_clr),
      .valid (sig_valid),
      .din   (sig_data),
      .sig   (misr_sig)
   );

   // R1: outputs sit at zero while reset is held
   always_comb begin
      if (!rst_n) begin
         p_reset_state_r1: assert (bus_data == '0 && !bus_en && misr_sig == '0);
      end
   end

endmodule

// File: tb/tpat_src_test.sv
module tpat_src_test;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_src = 2'b00;
   logic        cfg_tdm = 1'b0;
   logic [13:0] adc_data = '0;
   logic        adc_en = 1'b0;
   logic [13:0] bus_data;
   logic        bus_en;
   logic [15:0] sig_data = '0;
   logic        sig_valid = 1'b0;
   logic        misr_clr = 1'b0;
   logic [15:0] misr_sig;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   tpat_src uut (
      .clk(clk), .rst_n(rst_n), .cfg_src(cfg_src), .cfg_tdm(cfg_tdm),
      .adc_data(adc_data), .adc_en(adc_en), .bus_data(bus_data), .bus_en(bus_en),
      .sig_data(sig_data), .sig_valid(sig_valid), .misr_clr(misr_clr),
      .misr_sig(misr_sig)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [14:0] lfsr_step(input logic [14:0] s);
      return {s[13:0], s[14] ^ s[13]};
   endfunction

   function automatic logic [15:0] misr_step(input logic [15:0] s, input logic [15:0] d);
      logic [15:0] t;
      t = {s[14:0], 1'b0};
      if (s[15]) t = t ^ 16'h1021;
      return t ^ d;
   endfunction

   task automatic tick();
      @(negedge clk);
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [14:0] model;
      logic [15:0] msig;
      logic        exp_en;

      // R1: reset state
      tick(); tick();
      check("R1 bus_data", 32'(bus_data), 32'h0);
      check("R1 bus_en", 32'(bus_en), 32'h0);
      check("R1 misr_sig", 32'(misr_sig), 32'h0);
      rst_n = 1'b1;
      tick();

      // R2: every converter code, enable pattern varied, both live codes
      for (int i = 0; i < 16384; i++) begin
         cfg_src  = (i % 2 == 0) ? 2'b00 : 2'b01;
         cfg_tdm  = (i % 5 == 0);
         adc_data = 14'(i);
         adc_en   = i[0] ^ i[3];
         tick();
         check("R2 bus_data", 32'(bus_data), i & 32'h3fff);
         check("R2 bus_en / R6 tdm ignored", 32'(bus_en), 32'(i[0] ^ i[3]));
      end

      // R3 and R6: constant source, enable high, converter ignored
      cfg_tdm = 1'b0;
      for (int i = 0; i < 64; i++) begin
         cfg_src  = 2'b10;
         adc_data = 14'(i * 317);
         adc_en   = i[1];
         tick();
         check("R3 bus_data", 32'(bus_data), 32'h2000);
         check("R6 bus_en steady", 32'(bus_en), 32'h1);
      end

      // R6: interleave emulation alternates starting at 1
      cfg_tdm = 1'b1;
      exp_en  = 1'b1;
      for (int i = 0; i < 20; i++) begin
         tick();
         check("R6 toggle", 32'(bus_en), 32'(exp_en));
         check("R3 bus_data in tdm", 32'(bus_data), 32'h2000);
         exp_en = ~exp_en;
      end
      cfg_tdm = 1'b0;

      // R4: first PRBS words from the seed
      model = 15'h0001;
      cfg_src = 2'b11;
      for (int i = 0; i < 5; i++) begin
         tick();
         check("R4 prbs word", 32'(bus_data), 32'(model[13:0]));
         model = lfsr_step(model);
      end

      // R5: pause on converter data, then resume
      cfg_src = 2'b00;
      for (int i = 0; i < 10; i++) begin
         adc_data = 14'(16383 - i);
         adc_en   = 1'b1;
         tick();
         check("R5 live during pause", 32'(bus_data), 32'(16383 - i));
      end
      cfg_src = 2'b10;
      tick();
      check("R5 nfs during pause", 32'(bus_data), 32'h2000);

      // R4, R5: continue and run past a full period
      cfg_src = 2'b11;
      cfg_tdm = 1'b1;
      exp_en  = 1'b1;
      for (int i = 5; i < 32767 + 3; i++) begin
         tick();
         check("R4 R5 prbs sequence", 32'(bus_data), 32'(model[13:0]));
         check("R6 toggle in prbs", 32'(bus_en), 32'(exp_en));
         if (i == 32767) check("R4 period wrap to seed", 32'(bus_data), 32'h0001);
         model  = lfsr_step(model);
         exp_en = ~exp_en;
      end
      cfg_tdm = 1'b0;
      cfg_src = 2'b00;

      // R7, R8, R9: signature register
      msig = 16'h0;
      tick();
      check("R8 misr idle", 32'(misr_sig), 32'h0);
      for (int i = 0; i < 600; i++) begin
         sig_data  = 16'(i * 40503 + 7);
         sig_valid = (i % 3 != 0);
         misr_clr  = (i == 250) || (i == 251) || (i == 420);
         tick();
         if (misr_clr) begin
            msig = 16'h0;
            check("R9 clear", 32'(misr_sig), 32'(msig));
         end else if (sig_valid) begin
            msig = misr_step(msig, sig_data);
            check("R7 update", 32'(misr_sig), 32'(msig));
         end else begin
            check("R8 hold", 32'(misr_sig), 32'(msig));
         end
      end
      sig_valid = 1'b0;
      misr_clr  = 1'b0;
      tick();
      check("R8 final hold", 32'(misr_sig), 32'(msig));

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule